// File: doc/BRIEF.md
# Extended Low-Frequency Timebase

This block keeps system time from a slow 32768 Hz enable. A narrow base counter steps once per enable pulse while the timebase runs. Every time it rolls over to zero, a wider count of rollovers advances. Concatenating the two gives a wide tick value that will not wrap in any practical uptime.

The wide tick value is also turned into microseconds by exact rational scaling. Because 1000000/32768 reduces to 15625/512, the scaling needs a constant multiply and a shift rather than a divider. A second, purely combinational path takes a microsecond value and rounds it up to ticks, for alarm logic that has to know the first tick at or after a deadline. Start, stop and clear pulses control the count, and a sticky rollover flag is cleared by a write-one pulse.

Top module: `lf_timebase`

## Requirements
- R1: After reset the base counter, the rollover count, the rollover flag, the wide tick value and the microsecond time are all zero, and the timebase is stopped.
- R2: While running, the base counter rises by exactly one on each cycle where `tickEn` is 1, and holds on every other cycle.
- R3: When a step is taken with the base counter at its all-ones value (0xFFFFFF by default), the counter becomes 0 and the rollover count rises by one.
- R4: `ovfFlag` goes to 1 on a rollover step and stays at 1 until a cycle with `ovfClrPulse` at 1. A rollover and a clear pulse in the same cycle leave the flag at 1.
- R5: `extTicks` equals the rollover count in bits [55:24] and the base counter in bits [23:0].
- R6: `usTime` is the low 32 bits of floor(extTicks * 1000000 / 32768).
- R7: `usInTicks` is ceil(usIn * 32768 / 1000000), i.e. (usIn*32768 + 999999) / 1000000, with no clock cycle of delay.
- R8: A `clearPulse` sets the base counter and the rollover count to zero on the next edge. This takes priority over a step in the same cycle, and the rollover flag is not affected.
- R9: `startPulse` lets counting begin from the following cycle. `stopPulse` freezes both counts without clearing them from the following cycle. If both arrive together, stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | One-cycle enable at the 32768 Hz tick rate |
| startPulse | input | 1 | Begin counting |
| stopPulse | input | 1 | Freeze counting |
| clearPulse | input | 1 | Zero base counter and rollover count |
| ovfClrPulse | input | 1 | Write-one clear of the rollover flag |
| usIn | input | 32 | Microsecond value to convert to ticks |
| baseCount | output | 24 | Raw base counter |
| ovfFlag | output | 1 | Sticky rollover flag |
| extTicks | output | 56 | Rollover count and base counter joined |
| usTime | output | 32 | Current time in microseconds |
| usInTicks | output | 32 | usIn rounded up to ticks |

## Verification
The counters, the flag and the run state are registered, so any control pulse or enable that is present at a rising edge shows up on `baseCount`, `ovfFlag`, `extTicks` and `usTime` just after that edge. `usTime` follows from `extTicks` with no further delay. The bench sets its inputs at a falling edge and queues the expected state for the edge that follows. A monitor compares the queued state 2 ns after that rising edge, so every register result is checked in exactly the cycle it is due. `usInTicks` has no register, so it is checked 1 ns after `usIn` changes. The bench narrows the base counter through its parameter so that rollovers happen within a short run.

// File: rtl/lf_timebase_pkg.sv
package lf_timebase_pkg;

  typedef struct packed {
    logic clr;     // zero both counts
    logic adv;     // take one step
    logic wrap;    // step from all-ones
    logic flagClr; // write-one clear of sticky flag
  } ctrlStrobes_t;

  // strip common powers of two from num / 2**sh
  function automatic int unsigned reduceNum(int unsigned num, int sh);
    int unsigned n = num;
    int s = sh;
    while (s > 0 && (n % 2) == 0) begin
      n = n / 2;
      s = s - 1;
    end
    return n;
  endfunction

  function automatic int reduceShift(int unsigned num, int sh);
    int unsigned n = num;
    int s = sh;
    while (s > 0 && (n % 2) == 0) begin
      n = n / 2;
      s = s - 1;
    end
    return s;
  endfunction

endpackage

// File: rtl/lf_timebase_ctrl.sv
module lf_timebase_ctrl
  import lf_timebase_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         startPulse,
  input  logic         stopPulse,
  input  logic         clearPulse,
  input  logic         ovfClrPulse,
  input  logic         baseAtMax,
  output ctrlStrobes_t strobes
);

  logic running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (stopPulse) begin
      running <= 1'b0;
    end else if (startPulse) begin
      running <= 1'b1;
    end
  end

  always_comb begin
    strobes.clr     = clearPulse;
    strobes.adv     = running & tickEn & ~clearPulse;
    strobes.wrap    = running & tickEn & ~clearPulse & baseAtMax;
    strobes.flagClr = ovfClrPulse;
  end

endmodule

// File: rtl/lf_timebase_dp.sv
module lf_timebase_dp
  import lf_timebase_pkg::*;
#(
  parameter int          BASE_W      = 24,
  parameter int          OVF_W       = 32,
  parameter int          US_W        = 32,
  parameter int          TICKS_OUT_W = 32,
  parameter int unsigned TICK_HZ     = 32768,
  parameter int unsigned US_PER_S    = 1000000,
  localparam int         EXT_W       = BASE_W + OVF_W
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobes,
  input  logic [US_W-1:0]        usIn,
  output logic                   baseAtMax,
  output logic [BASE_W-1:0]      baseCount,
  output logic                   ovfFlag,
  output logic [EXT_W-1:0]       extTicks,
  output logic [US_W-1:0]        usTime,
  output logic [TICKS_OUT_W-1:0] usInTicks
);

  localparam int          TICK_SHIFT = $clog2(TICK_HZ);
  localparam int unsigned SCALE_NUM  = reduceNum(US_PER_S, TICK_SHIFT);
  localparam int          SCALE_SH   = reduceShift(US_PER_S, TICK_SHIFT);
  localparam int          NUM_W      = $clog2(SCALE_NUM + 1);
  localparam int          PROD_W     = EXT_W + NUM_W;
  localparam int          CEIL_W     = US_W + TICK_SHIFT + 1;

  logic [OVF_W-1:0] ovfCount;

  assign baseAtMax = &baseCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCount <= '0;
      ovfCount  <= '0;
    end else if (strobes.clr) begin
      baseCount <= '0;
      ovfCount  <= '0;
    end else if (strobes.adv) begin
      baseCount <= baseCount + 1'b1;
      if (strobes.wrap) ovfCount <= ovfCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ovfFlag <= 1'b0;
    else if (strobes.wrap)    ovfFlag <= 1'b1;
    else if (strobes.flagClr) ovfFlag <= 1'b0;
  end

  assign extTicks = {ovfCount, baseCount};

  // floor(ticks * US_PER_S / TICK_HZ) as constant multiply and shift
  logic [PROD_W-1:0] usProd;
  logic [PROD_W-1:0] usShifted;
  assign usProd    = {{NUM_W{1'b0}}, extTicks} * PROD_W'(SCALE_NUM);
  assign usShifted = usProd >> SCALE_SH;
  assign usTime    = usShifted[US_W-1:0];

  // ceil(us * TICK_HZ / US_PER_S)
  logic [CEIL_W-1:0] ceilNumer;
  logic [CEIL_W-1:0] ceilQuot;
  assign ceilNumer = {1'b0, usIn, {TICK_SHIFT{1'b0}}} + CEIL_W'(US_PER_S - 1);
  assign ceilQuot  = ceilNumer / CEIL_W'(US_PER_S);
  assign usInTicks = ceilQuot[TICKS_OUT_W-1:0];

endmodule

// File: rtl/lf_timebase.sv
module lf_timebase
  import lf_timebase_pkg::*;
#(
  parameter int          BASE_W      = 24,
  parameter int          OVF_W       = 32,
  parameter int          US_W        = 32,
  parameter int          TICKS_OUT_W = 32,
  parameter int unsigned TICK_HZ     = 32768,
  parameter int unsigned US_PER_S    = 1000000,
  localparam int         EXT_W       = BASE_W + OVF_W
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tickEn,
  input  logic                   startPulse,
  input  logic                   stopPulse,
  input  logic                   clearPulse,
  input  logic                   ovfClrPulse,
  input  logic [US_W-1:0]        usIn,
  output logic [BASE_W-1:0]      baseCount,
  output logic                   ovfFlag,
  output logic [EXT_W-1:0]       extTicks,
  output logic [US_W-1:0]        usTime,
  output logic [TICKS_OUT_W-1:0] usInTicks
);

  ctrlStrobes_t strobes;
  logic         baseAtMax;

  lf_timebase_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .startPulse  (startPulse),
    .stopPulse   (stopPulse),
    .clearPulse  (clearPulse),
    .ovfClrPulse (ovfClrPulse),
    .baseAtMax   (baseAtMax),
    .strobes     (strobes)
  );

  lf_timebase_dp #(
    .BASE_W      (BASE_W),
    .OVF_W       (OVF_W),
    .US_W        (US_W),
    .TICKS_OUT_W (TICKS_OUT_W),
    .TICK_HZ     (TICK_HZ),
    .US_PER_S    (US_PER_S)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .usIn      (usIn),
    .baseAtMax (baseAtMax),
    .baseCount (baseCount),
    .ovfFlag   (ovfFlag),
    .extTicks  (extTicks),
    .usTime    (usTime),
    .usInTicks (usInTicks)
  );

endmodule

// File: rtl/lf_timebase_chk.sv
module lf_timebase_chk #(
  parameter int BASE_W = 24,
  parameter int EXT_W  = 56
)(
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              stopPulse,
  input logic              clearPulse,
  input logic              ovfClrPulse,
  input logic [BASE_W-1:0] baseCount,
  input logic              ovfFlag,
  input logic [EXT_W-1:0]  extTicks
);

  localparam logic [BASE_W-1:0] MAXV = '1;

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!clearPulse && baseCount != MAXV) |=>
      (baseCount == $past(baseCount) || baseCount == $past(baseCount) + 1'b1));

  assert_wrap_carry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!clearPulse && baseCount == MAXV) |=>
      (baseCount == MAXV ||
       (baseCount == '0 &&
        extTicks[EXT_W-1:BASE_W] == $past(extTicks[EXT_W-1:BASE_W]) + 1'b1)));

  assert_flag_on_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!clearPulse && baseCount == MAXV) |=> (baseCount == MAXV || ovfFlag));

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClrPulse) |=> ovfFlag);

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    clearPulse |=> (extTicks == '0));

  assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stopPulse && !clearPulse) ##1 (!startPulse && !clearPulse) |=> $stable(extTicks));

endmodule

bind lf_timebase lf_timebase_chk #(
  .BASE_W (BASE_W),
  .EXT_W  (EXT_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startPulse  (startPulse),
  .stopPulse   (stopPulse),
  .clearPulse  (clearPulse),
  .ovfClrPulse (ovfClrPulse),
  .baseCount   (baseCount),
  .ovfFlag     (ovfFlag),
  .extTicks    (extTicks)
);

// File: tb/test_lf_timebase.sv
module test_lf_timebase;

  localparam int BW    = 6;   // narrowed so rollovers come quickly
  localparam int OW    = 32;
  localparam int EW    = BW + OW;
  localparam longint unsigned MAXB = (64'd1 << BW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tickEn = 1'b0, startPulse = 1'b0, stopPulse = 1'b0;
  logic          clearPulse = 1'b0, ovfClrPulse = 1'b0;
  logic [31:0]   usIn = '0;
  logic [BW-1:0] baseCount;
  logic          ovfFlag;
  logic [EW-1:0] extTicks;
  logic [31:0]   usTime;
  logic [31:0]   usInTicks;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lf_timebase #(.BASE_W(BW), .OVF_W(OW)) i_lf_timebase (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .startPulse(startPulse),
    .stopPulse(stopPulse), .clearPulse(clearPulse), .ovfClrPulse(ovfClrPulse),
    .usIn(usIn), .baseCount(baseCount), .ovfFlag(ovfFlag), .extTicks(extTicks),
    .usTime(usTime), .usInTicks(usInTicks)
  );

  typedef struct {
    longint unsigned base;
    longint unsigned ext;
    longint unsigned us;
    bit              flag;
    string           tag;
  } expItem_t;

  expItem_t expQ[$];

  // reference state
  longint unsigned mBase = 0, mOvf = 0;
  bit mFlag = 0, mRun = 0;

  task automatic checkState(expItem_t e);
    testsRun++;
    if (baseCount !== BW'(e.base) || extTicks !== EW'(e.ext) ||
        usTime !== 32'(e.us) || ovfFlag !== e.flag) begin
      testsFailed++;
      $display("FAIL %s: base=%0d ext=%0d us=%0d flag=%0b expected base=%0d ext=%0d us=%0d flag=%0b",
               e.tag, baseCount, extTicks, usTime, ovfFlag, e.base, e.ext, e.us, e.flag);
    end
  endtask

  task automatic step(bit tk, bit st, bit sp, bit cl, bit oc, string tag);
    expItem_t e;
    bit adv, wrap;
    @(negedge clk);
    tickEn = tk; startPulse = st; stopPulse = sp; clearPulse = cl; ovfClrPulse = oc;
    adv  = mRun && tk && !cl;
    wrap = adv && (mBase == MAXB);
    if (cl) begin
      mBase = 0; mOvf = 0;
    end else if (adv) begin
      if (wrap) begin
        mBase = 0; mOvf = (mOvf + 1) & 64'hFFFF_FFFF;
      end else mBase = mBase + 1;
    end
    if (wrap) mFlag = 1;
    else if (oc) mFlag = 0;
    if (sp) mRun = 0;
    else if (st) mRun = 1;
    e.base = mBase;
    e.ext  = (mOvf << BW) | mBase;
    e.us   = ((e.ext * 64'd1000000) / 64'd32768) & 64'hFFFF_FFFF;
    e.flag = mFlag;
    e.tag  = tag;
    expQ.push_back(e);
  endtask

  // monitor: compare 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) checkState(expQ.pop_front());
    end
  end

  task automatic checkConv(logic [31:0] u);
    longint unsigned ex;
    usIn = u;
    #1;
    ex = ((longint'(u) * 64'd32768) + 64'd999999) / 64'd1000000;
    testsRun++;
    if (usInTicks !== 32'(ex)) begin
      testsFailed++;
      $display("FAIL R7: usIn=%0d ticks=%0d expected %0d", u, usInTicks, ex);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    testsFailed++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    testsRun++;
    if (baseCount !== '0 || extTicks !== '0 || usTime !== '0 || ovfFlag !== 1'b0) begin
      testsFailed++;
      $display("FAIL R1: base=%0d ext=%0d us=%0d flag=%0b expected all zero",
               baseCount, extTicks, usTime, ovfFlag);
    end
    rstN = 1'b1;
    // R1/R9: stopped after reset, enables ignored
    repeat (3) step(1, 0, 0, 0, 0, "R1 stopped after reset");
    step(0, 1, 0, 0, 0, "R9 start");
    // R2 irregular enable pattern
    step(1, 0, 0, 0, 0, "R2 step");
    step(0, 0, 0, 0, 0, "R2 hold");
    step(1, 0, 0, 0, 0, "R2 step");
    step(1, 0, 0, 0, 0, "R2 step");
    step(0, 0, 0, 0, 0, "R2 hold");
    // R3/R4/R5/R6 roll over
    for (int i = 0; i < 70; i++) step(1, 0, 0, 0, 0, "R3 R5 R6 count through wrap");
    step(0, 0, 0, 0, 0, "R4 flag sticky");
    step(0, 0, 0, 0, 1, "R4 flag clear");
    // R4 wrap and clear together
    while (mBase != MAXB) step(1, 0, 0, 0, 0, "R6 approach wrap");
    step(1, 0, 0, 0, 1, "R4 wrap beats clear");
    step(0, 0, 0, 0, 0, "R4 flag held");
    // R9 stop freezes, stop wins over start
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, "R2 more counting");
    step(1, 0, 1, 0, 0, "R9 stop");
    repeat (3) step(1, 0, 0, 0, 0, "R9 frozen");
    step(1, 1, 1, 0, 0, "R9 stop wins");
    repeat (2) step(1, 0, 0, 0, 0, "R9 still frozen");
    step(1, 1, 0, 0, 0, "R9 restart");
    repeat (3) step(1, 0, 0, 0, 0, "R9 resumed");
    // R8 clear while running, with a step in the same cycle
    step(1, 0, 0, 1, 0, "R8 clear beats step");
    repeat (2) step(1, 0, 0, 0, 0, "R8 count after clear");
    step(0, 0, 1, 0, 0, "R9 stop");
    step(1, 0, 0, 1, 0, "R8 clear while stopped");
    step(0, 0, 0, 0, 0, "R8 idle");
    step(0, 0, 0, 0, 0, "R8 idle");
    @(negedge clk);
    // R7 ceiling conversion
    checkConv(32'd0);
    checkConv(32'd1);
    checkConv(32'd30);
    checkConv(32'd31);
    checkConv(32'd15625);
    checkConv(32'd15626);
    checkConv(32'd1000000);
    checkConv(32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    finish();
  end

endmodule